// File: doc/BRIEF.md
# Parallel-Port Nibble-Mode Register Access Sequencer

This block sits on the host side of a legacy parallel port and reaches the registers of a parallel-to-disk bridge through it. A single request carries a register index, a space select (0 for the drive register file, 1 for the command set), a read/write flag and a write byte. Once accepted, the sequencer plays a fixed program of data-line and control-line updates. Each update is held for a programmable number of clock cycles before the next one starts.

Every access opens with the same preamble. The preamble is built from two control strobe patterns and carries an address byte derived from the index and the space select. A write then presents its byte twice, each time followed by a strobe. A read uses one of two port widths. In nibble mode the byte is rebuilt from the upper four status lines, sampled in two separate strobe phases. In byte mode the byte is taken from the full data bus. The result is returned with a one-cycle done pulse.

Top module: `pps_reg_seq`

## Requirements
- R1: The address byte placed on the data lines is `index*4 + 1 + space`, modulo 256.
- R2: Control pattern A is the control-value series 5, D, 5, D, 5, 4 and pattern B is 5, 7, 5, 4. Only the control codes 4, 5, 6, 7, D and 0x26 ever appear. Control rests at 4 whenever the block is not busy.
- R3: Every access starts with this 19-step preamble: data 0x01, pattern A, the address byte, pattern B, data 0x00, pattern A.
- R4: After the preamble, a write runs: data = write byte, pattern B, data = write byte, pattern B. At done, `rd_data` reads 0x00.
- R5: A nibble-mode read (`rd_byte_mode`=0) follows the preamble with the control series 6, 4, 6, 4, 6, 4, 6, 4. Status is sampled at the end of the first and the second control-6 steps. The result's bits 3:0 are status bits 7:4 of the first sample, and its bits 7:4 are status bits 7:4 of the second sample.
- R6: A byte-mode read (`rd_byte_mode`=1) follows the preamble with the control series 0x26, 4, 0x26, 4. The result is `pd_in` sampled at the end of the first 0x26 step.
- R7: Each step holds its line values for `delay_cfg`+1 clock cycles. The value used is the one latched when the request is accepted. A whole access therefore keeps `busy` high for steps*(delay+1) cycles.
- R8: A request is accepted only when `busy` is low. `busy` rises on the next clock. Requests seen while busy are dropped and never run later.
- R9: `done` pulses for exactly one cycle, in the cycle after the last step ends. `busy` falls in that same cycle and `rd_data` is valid with it.
- R10: After reset: `pd_out`=0x00, `pc_out`=4, `busy`=0, `done`=0, `rd_data`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = drive register file, 1 = command set |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 8 | Write byte |
| rd_byte_mode | input | 1 | Read width: 0 = two status nibbles, 1 = full data bus |
| delay_cfg | input | DLY_W | Extra hold cycles per step |
| pd_out | output | 8 | Port data lines |
| pc_out | output | 6 | Port control lines |
| ps_in | input | 8 | Port status lines (bits 7:4 used) |
| pd_in | input | 8 | Port data lines read back in byte mode |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result |

## Verification
The hardest case to reach from the ports is a swap or misplacement of the status samples. The sampled value exists only for the final edge of one step, and a wrong sample point still yields a plausible byte. The bench therefore drives the correct nibble on the status lines only during the two sampling steps, and drives a distinct decoy value in every other step. It also uses read bytes with unequal nibbles, so that a swap or a shifted sample point changes the result. A request injected in mid-access, together with a changed delay setting, shows that neither disturbs the running trace and that nothing runs once the access is done.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int CTRL_W   = 6;
  localparam int STEP_W   = 5;
  localparam int PRE_LEN  = 19;

  typedef enum logic [1:0] {OP_WRITE, OP_RD_NIB, OP_RD_BYTE} op_e;
  typedef enum logic [1:0] {SMP_NONE, SMP_LO, SMP_HI, SMP_BUS} smp_e;

  typedef struct packed {
    logic       to_ctrl;
    logic [7:0] val;
    smp_e       smp;
  } step_t;

  // Address byte sent during the preamble.
  function automatic logic [7:0] addr_byte(logic [7:0] idx, logic space);
    return (idx << 2) + 8'd1 + {7'd0, space};
  endfunction

  // Strobe pattern A: six control values.
  function automatic logic [CTRL_W-1:0] pat_a(int i);
    case (i)
      1, 3:    return 6'h0D;
      5:       return 6'h04;
      default: return 6'h05;
    endcase
  endfunction

  // Strobe pattern B: four control values.
  function automatic logic [CTRL_W-1:0] pat_b(int i);
    case (i)
      1:       return 6'h07;
      3:       return 6'h04;
      default: return 6'h05;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] seq_len(op_e op);
    case (op)
      OP_WRITE:  return STEP_W'(PRE_LEN + 10);
      OP_RD_NIB: return STEP_W'(PRE_LEN + 8);
      default:   return STEP_W'(PRE_LEN + 4);
    endcase
  endfunction

  function automatic step_t mk_data(logic [7:0] v);
    step_t s;
    s.to_ctrl = 1'b0;
    s.val     = v;
    s.smp     = SMP_NONE;
    return s;
  endfunction

  function automatic step_t mk_ctrl(logic [CTRL_W-1:0] v, smp_e sm);
    step_t s;
    s.to_ctrl = 1'b1;
    s.val     = {2'b00, v};
    s.smp     = sm;
    return s;
  endfunction

  // Step k of the program selected by op.
  function automatic step_t step_of(op_e op, logic [STEP_W-1:0] k,
                                    logic [7:0] addr, logic [7:0] wd);
    int j;
    j = int'(k);
    if (j == 0)       return mk_data(8'h01);
    if (j <= 6)       return mk_ctrl(pat_a(j - 1), SMP_NONE);
    if (j == 7)       return mk_data(addr);
    if (j <= 11)      return mk_ctrl(pat_b(j - 8), SMP_NONE);
    if (j == 12)      return mk_data(8'h00);
    if (j <= 18)      return mk_ctrl(pat_a(j - 13), SMP_NONE);
    j = j - PRE_LEN;
    case (op)
      OP_WRITE: begin
        if (j == 0 || j == 5) return mk_data(wd);
        if (j < 5)            return mk_ctrl(pat_b(j - 1), SMP_NONE);
        return mk_ctrl(pat_b(j - 6), SMP_NONE);
      end
      OP_RD_NIB: begin
        if (j == 0)     return mk_ctrl(6'h06, SMP_LO);
        if (j == 2)     return mk_ctrl(6'h06, SMP_HI);
        if (j[0] == 0)  return mk_ctrl(6'h06, SMP_NONE);
        return mk_ctrl(6'h04, SMP_NONE);
      end
      default: begin
        if (j == 0)     return mk_ctrl(6'h26, SMP_BUS);
        if (j[0] == 0)  return mk_ctrl(6'h26, SMP_NONE);
        return mk_ctrl(6'h04, SMP_NONE);
      end
    endcase
  endfunction

endpackage

// File: rtl/pps_step_rom.sv
module pps_step_rom
  import pps_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] k,
  input  logic [7:0]        addr,
  input  logic [7:0]        wd,
  output step_t             st
);
  always_comb st = step_of(op, k, addr, wd);
endmodule

// File: rtl/pps_hold_timer.sv
module pps_hold_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DLY_W-1:0] limit,
  output logic             expire
);
  logic [DLY_W-1:0] cnt_q;

  assign expire = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start || expire)  cnt_q <= '0;
    else if (run)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pps_rd_capture.sv
module pps_rd_capture
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  smp_e       smp,
  input  logic [7:0] ps_in,
  input  logic [7:0] pd_in,
  output logic [7:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     result <= 8'h00;
    else if (clr)   result <= 8'h00;
    else if (take) begin
      case (smp)
        SMP_LO:  result[3:0] <= ps_in[7:4];
        SMP_HI:  result[7:4] <= ps_in[7:4];
        SMP_BUS: result      <= pd_in;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pps_reg_seq.sv
module pps_reg_seq
  import pps_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_space,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [7:0]        req_wdata,
  input  logic              rd_byte_mode,
  input  logic [DLY_W-1:0]  delay_cfg,
  output logic [7:0]        pd_out,
  output logic [CTRL_W-1:0] pc_out,
  input  logic [7:0]        ps_in,
  input  logic [7:0]        pd_in,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data
);
  localparam logic [CTRL_W-1:0] CTRL_REST = 6'h04;

  // Latched request
  op_e               op_q;
  logic [7:0]        addr_q;
  logic [7:0]        wd_q;
  logic [DLY_W-1:0]  dly_q;
  logic [STEP_W-1:0] step_q;

  // Named events
  logic  accept;
  logic  step_adv;
  logic  last_step;
  logic  expire;

  op_e               op_req;
  logic [7:0]        addr_req;
  op_e               nx_op;
  logic [STEP_W-1:0] nx_k;
  logic [7:0]        nx_addr;
  logic [7:0]        nx_wd;
  step_t             nx_st;
  step_t             cur_st;

  assign op_req    = req_write ? OP_WRITE : (rd_byte_mode ? OP_RD_BYTE : OP_RD_NIB);
  assign addr_req  = addr_byte(8'(req_idx), req_space);
  assign accept    = req_valid && !busy;
  assign step_adv  = busy && expire;
  assign last_step = (step_q == seq_len(op_q) - 1'b1);

  assign nx_op   = accept ? op_req    : op_q;
  assign nx_k    = accept ? '0        : step_q + 1'b1;
  assign nx_addr = accept ? addr_req  : addr_q;
  assign nx_wd   = accept ? req_wdata : wd_q;

  pps_step_rom u_next (
    .op(nx_op), .k(nx_k), .addr(nx_addr), .wd(nx_wd), .st(nx_st)
  );

  pps_step_rom u_cur (
    .op(op_q), .k(step_q), .addr(addr_q), .wd(wd_q), .st(cur_st)
  );

  pps_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy),
    .limit(dly_q), .expire(expire)
  );

  pps_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .take(step_adv),
    .smp(cur_st.smp), .ps_in(ps_in), .pd_in(pd_in), .result(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      op_q   <= OP_WRITE;
      addr_q <= 8'h00;
      wd_q   <= 8'h00;
      dly_q  <= '0;
      pd_out <= 8'h00;
      pc_out <= CTRL_REST;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        step_q <= '0;
        op_q   <= op_req;
        addr_q <= addr_req;
        wd_q   <= req_wdata;
        dly_q  <= delay_cfg;
      end else if (step_adv) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_q <= nx_k;
        end
      end
      if (accept || (step_adv && !last_step)) begin
        if (nx_st.to_ctrl) pc_out <= nx_st.val[CTRL_W-1:0];
        else               pd_out <= nx_st.val;
      end
    end
  end
endmodule

// File: rtl/pps_reg_seq_chk.sv
module pps_reg_seq_chk
  import pps_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic              step_adv,
  input logic [7:0]        pd_out,
  input logic [CTRL_W-1:0] pc_out,
  input logic [STEP_W-1:0] step_q,
  input op_e               op_q
);
  AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_adv) |=> ($stable(pd_out) && $stable(pc_out))); // R7
  AST_IDLE_CTRL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pc_out == 6'h04)); // R2
  AST_CTRL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_out == 6'h04 || pc_out == 6'h05 || pc_out == 6'h06 ||
     pc_out == 6'h07 || pc_out == 6'h0D || pc_out == 6'h26)); // R2
  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q < seq_len(op_q))); // R3
endmodule

bind pps_reg_seq pps_reg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .accept(accept),
  .step_adv(step_adv), .pd_out(pd_out), .pc_out(pc_out),
  .step_q(step_q), .op_q(op_q)
);

// File: tb/test_pps_reg_seq.sv
module test_pps_reg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_space = 0, rd_byte_mode = 0;
  logic [5:0] req_idx = '0;
  logic [7:0] req_wdata = '0, ps_in = '0, pd_in = '0;
  logic [7:0] delay_cfg = '0;
  logic [7:0] pd_out, rd_data;
  logic [5:0] pc_out;
  logic busy, done;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pps_reg_seq i_pps_reg_seq (.*);

  typedef struct packed {
    logic       wr;
    logic       sp;
    logic       wide;
    logic [5:0] idx;
    logic [7:0] wd;
    logic [7:0] rb;
    logic [3:0] dly;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 6'h06, 8'hA0, 8'h00, 4'd0},
    '{1'b1, 1'b1, 1'b0, 6'h3F, 8'h5A, 8'h00, 4'd2},
    '{1'b0, 1'b0, 1'b0, 6'h07, 8'h00, 8'hC3, 4'd1},
    '{1'b0, 1'b1, 1'b0, 6'h00, 8'h00, 8'h3C, 4'd0},
    '{1'b0, 1'b0, 1'b1, 6'h02, 8'h00, 8'h96, 4'd3},
    '{1'b0, 1'b1, 1'b1, 6'h1F, 8'h00, 8'h01, 4'd0}
  };

  // Expected trace, built from the requirements
  logic [7:0] ed [40];
  logic [5:0] ec [40];
  int n, smp_lo, smp_hi;
  logic [7:0] cd;
  logic [5:0] cc;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_d(input logic [7:0] v);
    cd = v; ed[n] = cd; ec[n] = cc; n++;
  endtask
  task automatic put_c(input logic [5:0] v);
    cc = v; ed[n] = cd; ec[n] = cc; n++;
  endtask
  task automatic str_a();
    put_c(6'h05); put_c(6'h0D); put_c(6'h05); put_c(6'h0D); put_c(6'h05); put_c(6'h04);
  endtask
  task automatic str_b();
    put_c(6'h05); put_c(6'h07); put_c(6'h05); put_c(6'h04);
  endtask

  task automatic build(input vec_t v);
    int a;
    n = 0; cd = 8'h00; cc = 6'h04; smp_lo = -1; smp_hi = -1;
    a = (int'(v.idx) * 4 + 1 + int'(v.sp)) % 256;
    put_d(8'h01); str_a(); put_d(8'(a)); str_b(); put_d(8'h00); str_a();
    if (v.wr) begin
      put_d(v.wd); str_b(); put_d(v.wd); str_b();
    end else if (!v.wide) begin
      smp_lo = n; put_c(6'h06); put_c(6'h04);
      smp_hi = n; put_c(6'h06); put_c(6'h04);
      put_c(6'h06); put_c(6'h04); put_c(6'h06); put_c(6'h04);
    end else begin
      smp_lo = n; put_c(6'h26); put_c(6'h04); put_c(6'h26); put_c(6'h04);
    end
  endtask

  function automatic string step_tag(input int k, input vec_t v);
    if (k == 7) return "R1 address byte";
    if (k == 0 || k == 12) return "R3 preamble data";
    if (k < 19) return "R2 strobe pattern";
    if (v.wr) return "R4 write tail";
    if (!v.wide) return "R5 nibble read tail";
    return "R6 byte read tail";
  endfunction

  task automatic run_access(input vec_t v, input bit inject);
    int busy_cycles;
    build(v);
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_space = v.sp; rd_byte_mode = v.wide;
    req_idx = v.idx; req_wdata = v.wd; delay_cfg = 8'(v.dly);
    @(negedge clk);
    req_valid = 0;
    busy_cycles = 0;
    for (int k = 0; k < n; k++) begin
      bit ok = 1;
      int act = 0;
      for (int c = 0; c <= int'(v.dly); c++) begin
        if (pd_out !== ed[k] || pc_out !== ec[k] || busy !== 1'b1) begin
          ok = 0; act = {busy, 2'b0, pc_out, pd_out};
        end
        if (busy) busy_cycles++;
        // status / bus stimulus: real value only in sampling steps
        if (!v.wide && k == smp_lo)      ps_in = {v.rb[3:0], 4'h9};
        else if (!v.wide && k == smp_hi) ps_in = {v.rb[7:4], 4'h6};
        else                             ps_in = 8'h27;
        pd_in = (v.wide && k == smp_lo) ? v.rb : 8'hE1;
        if (inject && k == 4 && c == 0) begin
          req_valid = 1; req_idx = ~v.idx; req_write = ~v.wr; delay_cfg = 8'd5;
        end else begin
          req_valid = 0;
        end
        @(negedge clk);
      end
      check(ok, step_tag(k, v), act, {1'b1, 2'b0, ec[k], ed[k]});
    end
    check(busy_cycles == n * (int'(v.dly) + 1), "R7 step hold length",
          busy_cycles, n * (int'(v.dly) + 1));
    check(done === 1'b1 && busy === 1'b0, "R9 done with busy low", {done, busy}, 2'b10);
    check(rd_data === (v.wr ? 8'h00 : v.rb), v.wr ? "R4 write result zero" :
          (v.wide ? "R6 byte read result" : "R5 nibble read result"),
          rd_data, v.wr ? 8'h00 : v.rb);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8 R9 single pulse, no queued request",
          {done, busy}, 2'b00);
    check(pc_out === 6'h04, "R2 control parked at 4", pc_out, 6'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pd_out === 8'h00 && pc_out === 6'h04 && busy === 1'b0 && done === 1'b0 &&
          rd_data === 8'h00, "R10 reset state",
          {busy, done, pc_out, pd_out}, {2'b00, 6'h04, 8'h00});
    // request during reset is not taken
    req_valid = 1;
    @(negedge clk);
    check(busy === 1'b0, "R10 no start in reset", busy, 0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) run_access(VEC[i], 1'b0);
    // corner: request and delay change injected mid-access
    run_access(VEC[2], 1'b1);
    run_access(VEC[1], 1'b1);
    // back-to-back after an injected access still runs normally
    run_access(VEC[4], 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule